// File: doc/BRIEF.md
# RTC configuration and interrupt controller

This block holds the eight-bit general configuration byte of a real-time clock and turns three time-keeping events into one level interrupt request. A host writes the byte through a simple write strobe and can read it back at any time. Four of the bits go straight to the time updater: update inhibit, binary data mode, 24-hour mode and the daylight-saving switch. Three further bits enable the interrupt sources, and one bit (square-wave enable) is only stored.

The two reset inputs are both synchronous and active high. Each affects only its own bits. The resume-well reset clears the periodic, update-ended and square-wave enables. The RTC-well reset clears only the alarm enable. The updater-facing bits ignore every reset and keep whatever value they held at power-up or got from the last write.

The periodic, alarm and update-ended events each set a sticky flag, whatever the enable state. The interrupt line is the registered OR over the three sources of (flag AND enable). It stays high until the host reads the flag register, which clears all three flags at once.

Top module: `rtc_cfg_irq`

## Requirements
- R1: A write (`cfg_wr`=1) with neither reset active stores `cfg_wdata`, and the stored byte appears on `cfg_rdata` on the next cycle. The bit layout is: bit 7 update inhibit, bit 6 periodic enable, bit 5 alarm enable, bit 4 update-ended enable, bit 3 square-wave enable, bit 2 binary mode, bit 1 24-hour mode, bit 0 daylight-saving enable. Bits 7, 2, 1 and 0 are also driven on `upd_inhibit`, `bin_mode`, `hr24_mode` and `dst_en`.
- R2: `rst_resume` clears bits 6, 4 and 3 (mask 0x58) on the next edge and changes no other configuration bit.
- R3: `rst_rtcwell` clears bit 5 (mask 0x20) on the next edge and changes no other configuration bit.
- R4: Bits 7, 2, 1 and 0 (mask 0x87) are changed by no reset. They power up to the parameter `INIT_CFG`.
- R5: When a write and a reset fall in the same cycle, the reset wins on the bits it clears, and the write still updates every other bit.
- R6: Each event input sets its flag one cycle later, whatever the enables are. The `stat_flags` positions are: bit 2 periodic, bit 1 alarm, bit 0 update-ended.
- R7: `flag_rd` clears all three flags on the next edge. An event in the same cycle sets its flag anyway.
- R8: Flags hold until they are read. `rst_resume` clears them, and `rst_rtcwell` does not.
- R9: `irq` equals, one cycle later, the OR of (periodic flag AND bit 6), (alarm flag AND bit 5) and (update flag AND bit 4). It is 0 after `rst_resume`.
- R10: Bit 3 has no effect on `irq` or on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_resume | input | 1 | Resume-well reset, synchronous, active high |
| rst_rtcwell | input | 1 | RTC-well reset, synchronous, active high |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Stored configuration byte |
| flag_rd | input | 1 | Flag register read; clears all flags |
| evt_periodic | input | 1 | Periodic tick event |
| evt_alarm | input | 1 | Alarm match event |
| evt_update | input | 1 | Update-ended event |
| stat_flags | output | 3 | Flags {periodic, alarm, update} |
| upd_inhibit | output | 1 | Update inhibit to the updater |
| bin_mode | output | 1 | Binary (1) / BCD (0) data mode |
| hr24_mode | output | 1 | 24-hour (1) / 12-hour (0) format |
| dst_en | output | 1 | Daylight-saving enable |
| irq | output | 1 | Level interrupt request |

## Verification
A bit that sits in the wrong reset domain shows on `cfg_rdata` on the first edge after that reset. The bench therefore applies each reset alone, both resets together, and each reset together with a write. It powers up with a non-zero `INIT_CFG` so that a wrongly cleared bit can be seen. A wrong flag or enable shows on `irq` one cycle after the flag output, and the bench checks both in every cycle. A lost event during a flag read, or a flag that clears too early, shows on `stat_flags` in the very next cycle.

// File: rtl/rtc_cfg_pkg.sv
package rtc_cfg_pkg;
  localparam int CFG_W = 8;
  localparam int NSRC  = 3;

  // configuration bit positions (decoded by the updater and irq logic)
  localparam int B_INHIBIT = 7;
  localparam int B_PER_EN  = 6;
  localparam int B_ALM_EN  = 5;
  localparam int B_UPD_EN  = 4;
  localparam int B_SQW_EN  = 3;
  localparam int B_BIN     = 2;
  localparam int B_HR24    = 1;
  localparam int B_DST     = 0;

  // source index inside the flag vector
  localparam int S_PER = 2;
  localparam int S_ALM = 1;
  localparam int S_UPD = 0;

  localparam logic [CFG_W-1:0] RESUME_MASK =
    (CFG_W'(1) << B_PER_EN) | (CFG_W'(1) << B_UPD_EN) | (CFG_W'(1) << B_SQW_EN);
  localparam logic [CFG_W-1:0] RTCWELL_MASK = CFG_W'(1) << B_ALM_EN;
endpackage

// File: rtl/rtc_cfg_reg.sv
module rtc_cfg_reg
  import rtc_cfg_pkg::*;
#(
  parameter logic [CFG_W-1:0] INIT_CFG = '0
) (
  input  logic             clk,
  input  logic             rst_resume,
  input  logic             rst_rtcwell,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg
);
  logic [CFG_W-1:0] cfg_q = INIT_CFG;
  logic [CFG_W-1:0] clr;
  logic [CFG_W-1:0] cfg_d;

  // per-bit reset domain selection
  always_comb begin
    clr = ({CFG_W{rst_resume}} & RESUME_MASK) | ({CFG_W{rst_rtcwell}} & RTCWELL_MASK);
    for (int i = 0; i < CFG_W; i++) begin
      if (clr[i])   cfg_d[i] = 1'b0;
      else if (wr)  cfg_d[i] = wdata[i];
      else          cfg_d[i] = cfg_q[i];
    end
  end

  always_ff @(posedge clk) cfg_q <= cfg_d;

  assign cfg = cfg_q;
endmodule

// File: rtl/rtc_evt_flags.sv
module rtc_evt_flags
  import rtc_cfg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_clr,
  input  logic [NSRC-1:0] evt,
  output logic [NSRC-1:0] flags
);
  logic [NSRC-1:0] flag_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)          flag_q[g] <= 1'b0;
      else if (evt[g])  flag_q[g] <= 1'b1;
      else if (rd_clr)  flag_q[g] <= 1'b0;
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/rtc_irq_gen.sv
module rtc_irq_gen
  import rtc_cfg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] flags,
  input  logic [NSRC-1:0] en,
  output logic            irq
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags & en);
  end

  assign irq = irq_q;
endmodule

// File: rtl/rtc_cfg_irq.sv
module rtc_cfg_irq
  import rtc_cfg_pkg::*;
#(
  parameter logic [7:0] INIT_CFG = 8'h00
) (
  input  logic       clk,
  input  logic       rst_resume,
  input  logic       rst_rtcwell,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       flag_rd,
  input  logic       evt_periodic,
  input  logic       evt_alarm,
  input  logic       evt_update,
  output logic [2:0] stat_flags,
  output logic       upd_inhibit,
  output logic       bin_mode,
  output logic       hr24_mode,
  output logic       dst_en,
  output logic       irq
);
  logic [CFG_W-1:0] cfg;
  logic [NSRC-1:0]  evt;
  logic [NSRC-1:0]  flags;
  logic [NSRC-1:0]  en;

  always_comb begin
    evt        = '0;
    evt[S_PER] = evt_periodic;
    evt[S_ALM] = evt_alarm;
    evt[S_UPD] = evt_update;
    en         = '0;
    en[S_PER]  = cfg[B_PER_EN];
    en[S_ALM]  = cfg[B_ALM_EN];
    en[S_UPD]  = cfg[B_UPD_EN];
  end

  rtc_cfg_reg #(.INIT_CFG(INIT_CFG)) u_reg (
    .clk(clk), .rst_resume(rst_resume), .rst_rtcwell(rst_rtcwell),
    .wr(cfg_wr), .wdata(cfg_wdata), .cfg(cfg)
  );

  rtc_evt_flags u_flags (
    .clk(clk), .rst(rst_resume), .rd_clr(flag_rd), .evt(evt), .flags(flags)
  );

  rtc_irq_gen u_irq (
    .clk(clk), .rst(rst_resume), .flags(flags), .en(en), .irq(irq)
  );

  assign cfg_rdata   = cfg;
  assign stat_flags  = flags;
  assign upd_inhibit = cfg[B_INHIBIT];
  assign bin_mode    = cfg[B_BIN];
  assign hr24_mode   = cfg[B_HR24];
  assign dst_en      = cfg[B_DST];
endmodule

// File: rtl/rtc_cfg_irq_chk.sv
module rtc_cfg_irq_chk (
  input logic       clk,
  input logic       rst_resume,
  input logic       rst_rtcwell,
  input logic       cfg_wr,
  input logic [7:0] cfg_wdata,
  input logic [7:0] cfg_rdata,
  input logic       flag_rd,
  input logic       evt_periodic,
  input logic       evt_alarm,
  input logic       evt_update,
  input logic [2:0] stat_flags,
  input logic       upd_inhibit,
  input logic       bin_mode,
  input logic       hr24_mode,
  input logic       dst_en,
  input logic       irq
);
  logic seen  = 1'b0;
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    seen <= 1'b1;
    if (rst_resume) armed <= 1'b1;
  end

  p_resume_clear_r2: assert property (@(posedge clk) disable iff (!seen)
    rst_resume |=> ((cfg_rdata & 8'h58) == 8'h00));

  p_rtcwell_clear_r3: assert property (@(posedge clk) disable iff (!seen)
    rst_rtcwell |=> (cfg_rdata[5] == 1'b0));

  p_keep_noreset_r4: assert property (@(posedge clk) disable iff (!seen)
    !cfg_wr |=> ((cfg_rdata & 8'h87) == ($past(cfg_rdata) & 8'h87)));

  p_read_clear_r7: assert property (@(posedge clk) disable iff (!armed)
    (flag_rd && !evt_periodic && !evt_alarm && !evt_update) |=> (stat_flags == 3'b000));

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!armed || rst_resume)
    !flag_rd |=> ((stat_flags & $past(stat_flags)) == $past(stat_flags)));

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!armed || rst_resume)
    irq |-> $past(|(stat_flags & {cfg_rdata[6], cfg_rdata[5], cfg_rdata[4]})));
endmodule

bind rtc_cfg_irq rtc_cfg_irq_chk u_chk (.*);

// File: tb/test_rtc_cfg_irq.sv
module test_rtc_cfg_irq;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] INIT = 8'hAF;

  logic clk = 1'b0;
  logic rst_resume = 1'b0, rst_rtcwell = 1'b0, cfg_wr = 1'b0, flag_rd = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic evt_periodic = 1'b0, evt_alarm = 1'b0, evt_update = 1'b0;
  logic [7:0] cfg_rdata;
  logic [2:0] stat_flags;
  logic upd_inhibit, bin_mode, hr24_mode, dst_en, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_cfg_irq #(.INIT_CFG(INIT)) i_rtc_cfg_irq (.*);

  typedef struct {
    logic [7:0] cfg;
    logic [2:0] flags;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t q[$];
  int vectors = 0, miscompares = 0;
  bit done = 0;

  // reference state, from the requirements
  logic [7:0] m_cfg = INIT;
  logic [2:0] m_flags = 3'b000;
  logic       m_irq = 1'b0;

  task automatic step(input bit wr, input logic [7:0] d, input bit rd,
                      input logic [2:0] ev, input bit rr, input bit rt, input string tag);
    logic [7:0] clr, ncfg;
    logic [2:0] en;
    exp_t e;
    @(negedge clk);
    cfg_wr = wr; cfg_wdata = d; flag_rd = rd;
    evt_periodic = ev[2]; evt_alarm = ev[1]; evt_update = ev[0];
    rst_resume = rr; rst_rtcwell = rt;
    @(posedge clk); #1;
    clr  = (rr ? 8'h58 : 8'h00) | (rt ? 8'h20 : 8'h00);   // R2 R3 R5
    ncfg = ((wr ? d : m_cfg) & ~clr);
    en   = {m_cfg[6], m_cfg[5], m_cfg[4]};
    m_irq   = rr ? 1'b0 : |(m_flags & en);                  // R9
    m_flags = rr ? 3'b000 : ((m_flags & ~{3{rd}}) | ev);    // R6 R7 R8
    m_cfg   = ncfg;
    e.cfg = m_cfg; e.flags = m_flags; e.irq = m_irq; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares one item per cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [14:0] act, expv;
      e = q.pop_front();
      act  = {cfg_rdata, stat_flags, irq, upd_inhibit, bin_mode, hr24_mode, dst_en};
      expv = {e.cfg, e.flags, e.irq, e.cfg[7], e.cfg[2], e.cfg[1], e.cfg[0]};
      vectors++;
      if (act !== expv) begin
        miscompares++;
        $display("FAIL %s actual=%h expected=%h", e.tag, act, expv);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    step(0, 8'h00, 0, 3'b000, 1, 0, "R2 R4 resume reset from power-up");   // A7
    step(0, 8'h00, 0, 3'b000, 0, 1, "R3 R4 rtc-well reset");               // 87
    step(0, 8'h00, 0, 3'b000, 0, 0, "R4 idle after resets");
    step(1, 8'h70, 0, 3'b000, 0, 0, "R1 write enables");
    step(0, 8'h00, 0, 3'b100, 0, 0, "R6 periodic event sets flag");
    step(0, 8'h00, 0, 3'b000, 0, 0, "R9 periodic irq rises");
    step(0, 8'h00, 1, 3'b000, 0, 0, "R7 read clears flags");
    step(0, 8'h00, 0, 3'b000, 0, 0, "R7 irq falls after read");
    step(1, 8'h00, 0, 3'b010, 0, 0, "R6 alarm flag with enables off");
    step(0, 8'h00, 0, 3'b000, 0, 0, "R9 no irq while disabled");
    step(1, 8'h20, 0, 3'b000, 0, 0, "R1 enable alarm");
    step(0, 8'h00, 0, 3'b000, 0, 0, "R9 pending alarm raises irq");
    step(0, 8'h00, 0, 3'b000, 0, 1, "R3 R8 rtc-well reset keeps flag");
    step(0, 8'h00, 0, 3'b000, 0, 0, "R9 irq falls with alarm enable");
    step(0, 8'h00, 1, 3'b001, 0, 0, "R7 event beats read");
    step(1, 8'h08, 0, 3'b000, 0, 0, "R10 square-wave bit set");
    step(0, 8'h00, 0, 3'b000, 0, 0, "R10 no irq from square-wave bit");
    step(0, 8'h00, 0, 3'b000, 0, 0, "R8 flag held");
    step(1, 8'hFF, 0, 3'b000, 1, 0, "R5 write with resume reset");
    step(1, 8'h7F, 0, 3'b000, 0, 1, "R5 write with rtc-well reset");
    step(0, 8'h00, 0, 3'b000, 1, 1, "R2 R3 both resets");
    step(1, 8'h78, 0, 3'b111, 0, 0, "R6 all events");
    step(0, 8'h00, 0, 3'b000, 0, 0, "R9 combined irq");
    step(0, 8'h00, 1, 3'b000, 0, 0, "R7 read clears all");
    step(0, 8'h00, 0, 3'b000, 0, 0, "R9 irq drops");
    step(0, 8'h00, 0, 3'b000, 0, 0, "R8 idle");
    @(negedge clk); @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule